// File: doc/BRIEF.md
# Register Window Rotation Controller

This block tracks where the active 16-register window sits inside a larger physical register file of `NAREG` registers, counted in groups of four. It holds two pieces of state: the current window base, a group index that wraps modulo `NAREG/4`, and a window-start mask with one bit per group that marks which groups begin a live call frame. The register file itself and the spill and fill handlers sit elsewhere. This controller decides, for each windowed control operation, whether the operation completes, traps as illegal, or needs a window spill or fill first. It also moves the base as that decision requires.

Four operations are accepted on a one-cycle request strobe: frame allocation at a call target (entry), windowed return, relative rotate, and a direct write of the base. Entry and return scan the window-start mask around the current base with wrap-around arithmetic. They report an overflow or underflow together with the frame size (4, 8 or 12 registers). On a trap the block also reports the old base to save, the trapping PC and the request to raise the exception-mode flag. A windowed return also yields its return address. The 2-bit frame size is carried in the top bits of the link register `a0`.

Every result is registered and shows up on the response outputs in the cycle after the strobe. `NAREG` must be a power of two between 32 and 64.

Top module: `regwin_ctrl`

## Requirements
- R1: While reset is held, and after reset is released, `win_base` is 0, `win_start` has only bit 0 set, and `rsp_valid` is low.
- R2: `req_op` selects the operation: 0 entry, 1 return, 2 rotate, 3 base write. A strobe on `req_valid` produces exactly one `rsp_valid` pulse in the next cycle, and the new `win_base`/`win_start` are visible in that same cycle. `rsp_kind` is encoded 0 success, 1 illegal, 2 overflow, 3 underflow.
- R3: An entry is illegal (kind 1) when `req_sreg` is greater than 3, when `req_woe` is 0, or when `req_excm` is 1. Any illegal operation leaves `win_base` and `win_start` unchanged.
- R4: On a legal entry, the block looks for the smallest n in 1..`req_callinc` whose window-start bit at base+n (mod `NAREG/4`) is set. If there is one, the result is an overflow (kind 2) and the base moves by n. `rsp_size` is 1 if the bit at base+n+1 is set, otherwise 2 if the bit at base+n+2 is set, otherwise 3 (meaning 4, 8 or 12 registers). The window-start mask is not changed.
- R5: A legal entry with no overflow moves the base by `req_callinc` modulo `NAREG/4`, sets the window-start bit of the new base, and reports success.
- R6: A return takes n = `req_a0[31:30]`. It takes m = 1, 2 or 3 for the nearest set window-start bit at base-1, base-2 or base-3, and m = 0 if none of them is set. The return is illegal if n is 0, if m is nonzero and different from n, if `req_woe` is 0, or if `req_excm` is 1.
- R7: A legal return reports `rsp_ret_pc` = {`req_pc[31:30]`, `req_a0[29:0]`}. An illegal return reports 0.
- R8: A legal return moves the base by -n. If the window-start bit at the new base is set, the bit of the old base is cleared and the result is success. Otherwise the mask is left as it is and the result is an underflow (kind 3) with `rsp_size` = n.
- R9: On overflow or underflow, `rsp_excm` is 1, `rsp_epc` equals the request PC, and `rsp_owb` equals the base held before the request.
- R10: On success or an illegal result, `rsp_excm`, `rsp_size`, `rsp_epc` and `rsp_owb` are all 0.
- R11: A rotate adds `req_rot`, read as a signed 4-bit value, to the base modulo `NAREG/4`. It leaves the mask unchanged and reports success.
- R12: A base write loads `req_base` into the base, leaves the mask unchanged and reports success.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle operation strobe |
| req_op | input | 2 | Operation select (0 entry, 1 return, 2 rotate, 3 base write) |
| req_pc | input | 32 | PC of the requesting instruction |
| req_a0 | input | 32 | Link register; bits 31:30 give the return frame size |
| req_callinc | input | 2 | Call increment of the frame being entered |
| req_woe | input | 1 | Window overflow enable from the status register |
| req_excm | input | 1 | Exception-mode flag from the status register |
| req_sreg | input | 4 | Stack register field of the entry instruction |
| req_rot | input | 4 | Signed rotate amount |
| req_base | input | log2(NAREG/4) | Value for a direct base write |
| rsp_valid | output | 1 | Response valid, one cycle after the strobe |
| rsp_kind | output | 2 | Outcome: 0 success, 1 illegal, 2 overflow, 3 underflow |
| rsp_size | output | 2 | Spill/fill size 1/2/3 = 4/8/12 registers, 0 otherwise |
| rsp_ret_pc | output | 32 | Return address of a legal return |
| rsp_epc | output | 32 | PC to record on a trap |
| rsp_owb | output | log2(NAREG/4) | Old base to save on a trap |
| rsp_excm | output | 1 | Request to set the exception-mode flag |
| win_base | output | log2(NAREG/4) | Current window base |
| win_start | output | NAREG/4 | Window-start mask |

## Verification
The assertions assume that the operands in a request (PC, opcode) are stable at the clock edge where the strobe is sampled, because the trap PC and the old base are compared with their values one edge earlier. They also assume that no strobe arrives while reset is asserted. The bench drives every input on the falling edge and holds it until the next falling edge. It raises the strobe only after reset has been released. The random stimulus mostly keeps the status flags in the legal setting and the register field within 0..3, with an occasional illegal value mixed in. Return frame sizes are drawn from all four codes, so the mismatch and zero-size paths are also hit.

// File: rtl/regwin_ctrl.sv
module regwin_ctrl #(
  parameter int NAREG = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [1:0]                    req_op,
  input  logic [31:0]                   req_pc,
  input  logic [31:0]                   req_a0,
  input  logic [1:0]                    req_callinc,
  input  logic                          req_woe,
  input  logic                          req_excm,
  input  logic [3:0]                    req_sreg,
  input  logic [3:0]                    req_rot,
  input  logic [$clog2(NAREG/4)-1:0]    req_base,
  output logic                          rsp_valid,
  output logic [1:0]                    rsp_kind,
  output logic [1:0]                    rsp_size,
  output logic [31:0]                   rsp_ret_pc,
  output logic [31:0]                   rsp_epc,
  output logic [$clog2(NAREG/4)-1:0]    rsp_owb,
  output logic                          rsp_excm,
  output logic [$clog2(NAREG/4)-1:0]    win_base,
  output logic [NAREG/4-1:0]            win_start
);
  localparam int NGRP = NAREG / 4;
  localparam int BW   = $clog2(NGRP);
  typedef logic [BW-1:0] grp_t;

  localparam logic [1:0] OP_ENTRY = 2'd0, OP_RETW = 2'd1, OP_ROTW = 2'd2, OP_SETB = 2'd3;
  localparam logic [1:0] K_OK = 2'd0, K_ILL = 2'd1, K_OVF = 2'd2, K_UNF = 2'd3;

  function automatic grp_t offs(input grp_t b, input int k);
    return grp_t'(int'(b) + k);
  endfunction

  logic fwd1, fwd2, fwd3, bck1, bck2, bck3;
  assign fwd1 = win_start[offs(win_base, 1)];
  assign fwd2 = win_start[offs(win_base, 2)];
  assign fwd3 = win_start[offs(win_base, 3)];
  assign bck1 = win_start[offs(win_base, -1)];
  assign bck2 = win_start[offs(win_base, -2)];
  assign bck3 = win_start[offs(win_base, -3)];

  logic [1:0] ovf_n, ovf_size, ret_n, ret_m;
  grp_t       ovf_grp, ret_grp;
  logic       ent_ill, ret_ill;

  assign ovf_n = (req_callinc >= 2'd1 && fwd1) ? 2'd1 :
                 (req_callinc >= 2'd2 && fwd2) ? 2'd2 :
                 (req_callinc == 2'd3 && fwd3) ? 2'd3 : 2'd0;
  assign ovf_grp  = offs(win_base, int'(ovf_n));
  assign ovf_size = win_start[offs(ovf_grp, 1)] ? 2'd1 :
                    win_start[offs(ovf_grp, 2)] ? 2'd2 : 2'd3;
  assign ent_ill  = (req_sreg > 4'd3) || !req_woe || req_excm;

  assign ret_n   = req_a0[31:30];
  assign ret_m   = bck1 ? 2'd1 : bck2 ? 2'd2 : bck3 ? 2'd3 : 2'd0;
  assign ret_grp = offs(win_base, -int'(ret_n));
  assign ret_ill = (ret_n == 2'd0) || (ret_m != 2'd0 && ret_m != ret_n) || !req_woe || req_excm;

  grp_t              nxt_base;
  logic [NGRP-1:0]   nxt_start;
  logic [1:0]        nxt_kind, nxt_size;
  logic [31:0]       nxt_ret_pc, nxt_epc;
  logic              nxt_trap;

  always_comb begin
    nxt_base   = win_base;
    nxt_start  = win_start;
    nxt_kind   = K_OK;
    nxt_size   = 2'd0;
    nxt_ret_pc = 32'd0;
    nxt_trap   = 1'b0;
    unique case (req_op)
      OP_ENTRY: begin
        if (ent_ill) begin
          nxt_kind = K_ILL;
        end else if (ovf_n != 2'd0) begin
          nxt_kind = K_OVF;
          nxt_size = ovf_size;
          nxt_base = ovf_grp;
          nxt_trap = 1'b1;
        end else begin
          nxt_base = offs(win_base, int'(req_callinc));
          nxt_start[nxt_base] = 1'b1;
        end
      end
      OP_RETW: begin
        if (ret_ill) begin
          nxt_kind = K_ILL;
        end else begin
          nxt_ret_pc = {req_pc[31:30], req_a0[29:0]};
          nxt_base   = ret_grp;
          if (win_start[ret_grp]) begin
            nxt_start[win_base] = 1'b0;
          end else begin
            nxt_kind = K_UNF;
            nxt_size = ret_n;
            nxt_trap = 1'b1;
          end
        end
      end
      OP_ROTW: nxt_base = offs(win_base, int'($signed(req_rot)));
      default: nxt_base = req_base;
    endcase
  end

  assign nxt_epc = nxt_trap ? req_pc : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_base   <= '0;
      win_start  <= NGRP'(1);
      rsp_valid  <= 1'b0;
      rsp_kind   <= K_OK;
      rsp_size   <= 2'd0;
      rsp_ret_pc <= 32'd0;
      rsp_epc    <= 32'd0;
      rsp_owb    <= '0;
      rsp_excm   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        win_base   <= nxt_base;
        win_start  <= nxt_start;
        rsp_kind   <= nxt_kind;
        rsp_size   <= nxt_size;
        rsp_ret_pc <= nxt_ret_pc;
        rsp_epc    <= nxt_epc;
        rsp_owb    <= nxt_trap ? win_base : '0;
        rsp_excm   <= nxt_trap;
      end
    end
  end
endmodule

// File: rtl/regwin_ctrl_chk.sv
module regwin_ctrl_chk #(
  parameter int NAREG = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic [1:0]                 req_op,
  input logic [31:0]                req_pc,
  input logic                       rsp_valid,
  input logic [1:0]                 rsp_kind,
  input logic [1:0]                 rsp_size,
  input logic [31:0]                rsp_epc,
  input logic [$clog2(NAREG/4)-1:0] rsp_owb,
  input logic                       rsp_excm,
  input logic [$clog2(NAREG/4)-1:0] win_base,
  input logic [NAREG/4-1:0]         win_start
);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  rsp_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R3
  illegal_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'd1) |-> (win_base == $past(win_base) && win_start == $past(win_start)));

  // R5
  entry_marks_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'd0 && $past(req_op) == 2'd0) |-> win_start[win_base]);

  // R8
  return_frees_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'd0 && $past(req_op) == 2'd1) |->
      (!win_start[$past(win_base)] && win_start[win_base]));

  // R9
  trap_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind[1]) |->
      (rsp_excm && rsp_size != 2'd0 && rsp_epc == $past(req_pc) && rsp_owb == $past(win_base)));

  // R10
  quiet_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_kind[1]) |-> (!rsp_excm && rsp_size == 2'd0 && rsp_epc == 32'd0));
endmodule

bind regwin_ctrl regwin_ctrl_chk #(.NAREG(NAREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_pc(req_pc),
  .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_size(rsp_size), .rsp_epc(rsp_epc),
  .rsp_owb(rsp_owb), .rsp_excm(rsp_excm), .win_base(win_base), .win_start(win_start)
);

// File: tb/sim_regwin_ctrl.sv
module sim_regwin_ctrl;
  localparam int NAREG = 64;
  localparam int NGRP  = NAREG / 4;
  localparam int BW    = $clog2(NGRP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [31:0] req_pc = '0, req_a0 = '0;
  logic [1:0] req_callinc = '0;
  logic req_woe = 1'b0, req_excm = 1'b0;
  logic [3:0] req_sreg = '0, req_rot = '0;
  logic [BW-1:0] req_base = '0;
  logic rsp_valid, rsp_excm;
  logic [1:0] rsp_kind, rsp_size;
  logic [31:0] rsp_ret_pc, rsp_epc;
  logic [BW-1:0] rsp_owb, win_base;
  logic [NGRP-1:0] win_start;

  always #10 clk = ~clk;

  regwin_ctrl #(.NAREG(NAREG)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_pc(req_pc),
    .req_a0(req_a0), .req_callinc(req_callinc), .req_woe(req_woe), .req_excm(req_excm),
    .req_sreg(req_sreg), .req_rot(req_rot), .req_base(req_base),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_size(rsp_size), .rsp_ret_pc(rsp_ret_pc),
    .rsp_epc(rsp_epc), .rsp_owb(rsp_owb), .rsp_excm(rsp_excm),
    .win_base(win_base), .win_start(win_start)
  );

  int n_chk = 0, n_bad = 0;
  logic [BW-1:0]   ref_base = '0;
  logic [NGRP-1:0] ref_ws = NGRP'(1);

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic ws_at(input logic [BW-1:0] b, input int k);
    logic [BW-1:0] idx;
    idx = BW'(int'(b) + k);
    return ref_ws[idx];
  endfunction

  task automatic run(input logic [1:0] op, input logic [31:0] pc, input logic [31:0] a0,
                     input logic [1:0] ci, input logic woe, input logic excm,
                     input logic [3:0] sreg, input logic [3:0] rot, input logic [BW-1:0] bv);
    logic [1:0] ek, es;
    logic [31:0] erp, eep;
    logic [BW-1:0] eow, old;
    logic ex;
    int n, m;
    string tag;
    ek = 0; es = 0; erp = 0; eep = 0; eow = 0; ex = 0; old = ref_base;
    tag = "R12";
    req_op = op; req_pc = pc; req_a0 = a0; req_callinc = ci; req_woe = woe;
    req_excm = excm; req_sreg = sreg; req_rot = rot; req_base = bv; req_valid = 1'b1;
    case (op)
      2'd0: begin
        if (sreg > 4'd3 || !woe || excm) begin ek = 1; tag = "R3"; end
        else begin
          n = 0;
          for (int k = 1; k <= 3; k++) if (n == 0 && k <= int'(ci) && ws_at(old, k)) n = k;
          if (n != 0) begin
            ek = 2; tag = "R4"; ex = 1; eep = pc; eow = old;
            es = ws_at(old, n + 1) ? 2'd1 : ws_at(old, n + 2) ? 2'd2 : 2'd3;
            ref_base = BW'(int'(old) + n);
          end else begin
            tag = "R5";
            ref_base = BW'(int'(old) + int'(ci));
            ref_ws[ref_base] = 1'b1;
          end
        end
      end
      2'd1: begin
        n = int'(a0[31:30]);
        m = 0;
        for (int k = 3; k >= 1; k--) if (ws_at(old, -k)) m = k;
        if (n == 0 || (m != 0 && m != n) || !woe || excm) begin ek = 1; tag = "R6"; end
        else begin
          erp = {pc[31:30], a0[29:0]};
          ref_base = BW'(int'(old) - n);
          if (ref_ws[ref_base]) begin ref_ws[old] = 1'b0; tag = "R8"; end
          else begin ek = 3; es = 2'(n); ex = 1; eep = pc; eow = old; tag = "R8"; end
        end
      end
      2'd2: begin tag = "R11"; ref_base = BW'(int'(old) + int'($signed(rot))); end
      default: begin tag = "R12"; ref_base = bv; end
    endcase
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(tag, "kind", 32'(rsp_kind), 32'(ek));
    chk(tag, "base", 32'(win_base), 32'(ref_base));
    chk(tag, "start", 32'(win_start), 32'(ref_ws));
    chk(ex ? "R9" : "R10", "size", 32'(rsp_size), 32'(es));
    chk(ex ? "R9" : "R10", "excm", 32'(rsp_excm), 32'(ex));
    chk(ex ? "R9" : "R10", "epc", rsp_epc, eep);
    chk(ex ? "R9" : "R10", "owb", 32'(rsp_owb), 32'(eow));
    if (op == 2'd1) chk("R7", "ret_pc", rsp_ret_pc, erp);
  endtask

  task automatic idle_chk();
    @(negedge clk);
    chk("R2", "rsp_valid idle", 32'(rsp_valid), 32'd0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1", "base in reset", 32'(win_base), 32'd0);
    chk("R1", "start in reset", 32'(win_start), 32'd1);
    chk("R1", "valid in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "base after reset", 32'(win_base), 32'd0);
    chk("R1", "start after reset", 32'(win_start), 32'd1);

    // R3: each illegal entry condition
    run(2'd0, 32'h1000, 0, 2'd1, 1, 0, 4'd4, 0, 0);
    run(2'd0, 32'h1004, 0, 2'd1, 0, 0, 4'd1, 0, 0);
    run(2'd0, 32'h1008, 0, 2'd1, 1, 1, 4'd1, 0, 0);
    idle_chk();
    // R5 then R7/R8 success returns
    run(2'd0, 32'h2000, 0, 2'd1, 1, 0, 4'd1, 0, 0);
    run(2'd0, 32'h2004, 0, 2'd2, 1, 0, 4'd1, 0, 0);
    run(2'd1, 32'hC000_3000, 32'h8000_1234, 0, 1, 0, 0, 0, 0);
    run(2'd1, 32'h4000_3004, 32'h4ABC_DEF0, 0, 1, 0, 0, 0, 0);
    // R8 underflow of size 4
    run(2'd1, 32'h3008, 32'h4000_0010, 0, 1, 0, 0, 0, 0);
    idle_chk();
    // R12 then R4 overflow wrapping past the top group, size 12
    run(2'd3, 0, 0, 0, 0, 0, 0, 0, BW'(NGRP - 2));
    run(2'd0, 32'h5000, 0, 2'd2, 1, 0, 4'd0, 0, 0);
    // R11 negative rotate wraps
    run(2'd2, 0, 0, 0, 0, 0, 0, 4'hF, 0);
    // R6 zero size and mismatched size
    run(2'd1, 32'h6000, 32'h0000_0100, 0, 1, 0, 0, 0, 0);
    run(2'd3, 0, 0, 0, 0, 0, 0, 0, BW'(2));
    run(2'd1, 32'h6004, 32'hC000_0100, 0, 1, 0, 0, 0, 0);
    run(2'd1, 32'h6008, 32'h8000_0100, 0, 0, 0, 0, 0, 0);
    idle_chk();

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] op;
      logic [3:0] sr;
      op = 2'($urandom_range(0, 9) < 4 ? 0 : $urandom_range(1, 3));
      sr = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(4, 15)) : 4'($urandom_range(0, 3));
      run(op, $urandom, $urandom, 2'($urandom_range(0, 3)),
          $urandom_range(0, 9) != 0, $urandom_range(0, 9) == 0, sr,
          4'($urandom_range(0, 15)), BW'($urandom_range(0, NGRP - 1)));
      if ($urandom_range(0, 15) == 0) idle_chk();
    end

    summary();
    $finish;
  end
endmodule